// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Stop Time

The block turns bytes into asynchronous serial frames on one output line. The line rests high. A frame is one low start bit, then the eight data bits with the least significant bit first, then a run of high stop bits. The run is one to four bit times long and is chosen at run time. Bit timing comes from an outside baud tick, which pulses for one clock cycle per bit period. The line changes only on the clock edge that samples a tick.

Bytes arrive on a valid/ready handshake. The input opens while the line is idle, and again during the last stop bit of the current frame. A byte taken in that last stop bit starts its frame right after that stop bit. So with one stop bit selected, a stream of bytes goes out with no idle time between frames. A longer stop run makes the transmitter slightly slower than a receiver on the same nominal rate. Echo traffic then cannot build up a backlog when the two baud clocks differ a little. The stop setting is read only when a frame starts.

Top module: `utx_serializer`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `tx_line` is 1 and `in_ready` is 1.
- R2: The idle line is high. A byte accepted while idle starts its frame on the next clock edge that samples `baud_tick`, where `tx_line` goes to 0 for exactly one bit period.
- R3: After the start bit, the eight data bits appear on `tx_line` least significant bit first, one per bit period.
- R4: A `stop_sel` value v (0 to 3) gives v+1 high stop bit periods after the data bits. Value 0 is one stop bit and value 3 is four.
- R5: With `stop_sel` = 0, and the next byte offered before the final stop bit ends, the next start bit follows the single stop bit with no idle bit period in between.
- R6: `in_ready` is 1 only while the line is idle or in the final stop bit, and only when no accepted byte is waiting. It is 0 in the cycle after any accepted byte and whenever `tx_line` is low.
- R7: `stop_sel` is sampled at the edge where a frame starts. A change during the frame does not alter that frame's stop run.
- R8: `tx_line` changes only on a clock edge at which `baud_tick` is 1, so every bit lasts a whole number of tick periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| stop_sel | input | STOP_W (2) | Stop bit count minus one |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_data | input | DATA_W (8) | Byte to send |
| in_ready | output | 1 | A byte is taken on this edge when `in_valid` is 1 |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
A wrong bit counter shows up as a frame whose data appears shifted by one position, or as a start bit too early or too late. This is visible at the first frame boundary, within one frame time. A stuck or mis-latched stop counter changes the number of high bit periods between two frames, so back-to-back streams with mixed settings expose it on the next boundary. A handshake error shows up as `in_ready` high while the line is low, or high just after a capture. The port-level properties catch either case on the very next clock edge.

// File: rtl/utx_pkg.sv
// Shared types for the serial transmitter.
// Assumes nothing beyond standard SystemVerilog packages.
package utx_pkg;

    // Frame phase of the transmitter
    typedef enum logic [1:0] {
        UTX_IDLE  = 2'd0,
        UTX_START = 2'd1,
        UTX_DATA  = 2'd2,
        UTX_STOP  = 2'd3
    } utx_state_e;

endpackage

// File: rtl/utx_hold.sv
// Single-entry holding register for one byte waiting to be framed.
// Assumes push and take are never both meaningful for the same byte:
// a byte that is framed on the edge it arrives is never pushed.
module utx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data_out
);

    // Store an accepted byte, release it when a frame loads it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full     <= 1'b0;
            data_out <= '0;
        end else if (take) begin
            full     <= 1'b0;
        end else if (push) begin
            full     <= 1'b1;
            data_out <= push_data;
        end
    end

endmodule

// File: rtl/utx_shift.sv
// Output shift register. It holds the start bit and the data bits.
// It refills with ones from the top, so once the data is gone the
// line is high for stop and idle time with no extra mux.
// Assumes load has priority over advance.
module utx_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              adv,
    output logic              line
);

    localparam int SH_W = DATA_W + 1;

    logic [SH_W-1:0] sh_q;

    // Load a new frame or move one bit toward the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else if (load) begin
            sh_q <= {load_data, 1'b0};
        end else if (adv) begin
            sh_q <= {1'b1, sh_q[SH_W-1:1]};
        end
    end

    assign line = sh_q[0];

endmodule

// File: rtl/utx_ctl.sv
// Frame sequencer. It counts bit periods on baud ticks, runs the
// stop-bit countdown and decides when the next frame loads.
// Assumes baud_tick is a single-cycle pulse and that pending stays
// true until load is given.
module utx_ctl #(
    parameter int DATA_W = 8,
    parameter int STOP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              pending,
    input  logic [STOP_W-1:0] stop_sel,
    output logic              load,
    output logic              adv,
    output logic              slot_open,
    output logic [STOP_W-1:0] stop_lat
);

    import utx_pkg::*;

    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    utx_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [STOP_W-1:0] left_q;
    logic              last_stop;

    // Final stop bit is the moment a following frame may be taken
    always_comb begin
        last_stop = (state_q == UTX_STOP) && (left_q == '0);
        slot_open = (state_q == UTX_IDLE) || last_stop;
        load      = tick && pending && slot_open;
        adv       = tick && ((state_q == UTX_START) || (state_q == UTX_DATA));
    end

    // Phase sequencing on each baud tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= UTX_IDLE;
            idx_q    <= '0;
            left_q   <= '0;
            stop_lat <= '0;
        end else if (tick) begin
            unique case (state_q)
                UTX_IDLE: begin
                    if (pending) begin
                        state_q  <= UTX_START;
                        stop_lat <= stop_sel;
                    end
                end
                UTX_START: begin
                    state_q <= UTX_DATA;
                    idx_q   <= '0;
                end
                UTX_DATA: begin
                    if (idx_q == LAST_IDX) begin
                        state_q <= UTX_STOP;
                        left_q  <= stop_lat;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                UTX_STOP: begin
                    if (left_q != '0) begin
                        left_q <= left_q - 1'b1;
                    end else if (pending) begin
                        state_q  <= UTX_START;
                        stop_lat <= stop_sel;
                    end else begin
                        state_q <= UTX_IDLE;
                    end
                end
                default: state_q <= UTX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/utx_serializer.sv
// Top of the serial transmitter: handshake, holding register,
// sequencer and output shifter.
// Assumes baud_tick comes from a rate generator in the same clock
// domain. A byte offered on a tick edge while the slot is open goes
// straight into the shifter, so no bit period is lost.
module utx_serializer #(
    parameter int DATA_W = 8,
    parameter int STOP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [STOP_W-1:0] stop_sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_line
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              accept;
    logic              pending;
    logic              load;
    logic              adv;
    logic              slot_open;
    logic [STOP_W-1:0] stop_lat;
    logic [DATA_W-1:0] frame_data;

    // Handshake and bypass selection
    always_comb begin
        in_ready   = slot_open && !hold_full;
        accept     = in_valid && in_ready;
        pending    = hold_full || accept;
        frame_data = hold_full ? hold_data : in_data;
    end

    utx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept && !load),
        .push_data (in_data),
        .take      (load),
        .full      (hold_full),
        .data_out  (hold_data)
    );

    utx_ctl #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .pending   (pending),
        .stop_sel  (stop_sel),
        .load      (load),
        .adv       (adv),
        .slot_open (slot_open),
        .stop_lat  (stop_lat)
    );

    utx_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (frame_data),
        .adv       (adv),
        .line      (tx_line)
    );

endmodule

// File: rtl/utx_serializer_chk.sv
// Property checker for the serial transmitter, bound to the top.
// Assumes the reset is held low from time zero.
module utx_serializer_chk #(
    parameter int STOP_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              baud_tick,
    input logic              in_valid,
    input logic              in_ready,
    input logic              tx_line,
    input logic              load,
    input logic [STOP_W-1:0] stop_lat
);

    AST_RESET_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (tx_line && in_ready)); // R1

    AST_START_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load)) |-> !tx_line); // R2

    AST_LOW_LINE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_line |-> !in_ready); // R6

    AST_CAPTURE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid && in_ready)) |-> !in_ready); // R6

    AST_STOP_SETTING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> $stable(stop_lat)); // R7

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(baud_tick)) |-> $stable(tx_line)); // R8

endmodule

bind utx_serializer utx_serializer_chk #(.STOP_W(STOP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_line   (tx_line),
    .load      (load),
    .stop_lat  (stop_lat)
);

// File: tb/tb_utx_serializer.sv
module tb_utx_serializer;

    localparam int P = 8;
    localparam int NV = 6;
    // {stop_sel[1:0], data[7:0]}
    localparam logic [9:0] VEC [NV] = '{10'h055, 10'h1A3, 10'h000,
                                        10'h3FF, 10'h281, 10'h03C};

    logic       clk = 1'b0;
    logic       rst_n;
    logic       baud_tick;
    logic [1:0] stop_sel;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_ready;
    logic       tx_line;

    always #5 clk = ~clk;

    utx_serializer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .stop_sel  (stop_sel),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .tx_line   (tx_line)
    );

    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    logic log_b [512];
    int   log_n  = 0;
    logic [7:0] exp_data [16];
    int         exp_stop [16];

    // Tick every P cycles; record the line once per bit period
    initial begin
        baud_tick = 1'b0;
        forever begin
            repeat (P - 1) @(negedge clk);
            baud_tick = 1'b1;
            @(negedge clk);
            baud_tick = 1'b0;
            if (log_n < 512) begin
                log_b[log_n] = tx_line;
                log_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic [1:0] sel);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        stop_sel = sel;
        in_valid = 1'b1;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R6", "ready after capture", in_ready, 0);
    endtask

    task automatic check_frames(input int n);
        int i = 0;
        chk(log_b[0] == 1'b1, "R2", "idle line before frame", log_b[0], 1);
        while (i < log_n && log_b[i] == 1'b1) i++;
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            int g;
            chk(log_b[i] == 1'b0, "R2", "start bit", log_b[i], 0);
            for (int j = 0; j < 8; j++) d[j] = log_b[i + 1 + j];
            chk(d == exp_data[k], "R3", "data bits LSB first", d, exp_data[k]);
            i = i + 9;
            g = 0;
            while (i < log_n && log_b[i] == 1'b1) begin
                g++;
                i++;
            end
            if (k < n - 1)
                chk(g == exp_stop[k], (exp_stop[k] == 1) ? "R5" : "R4",
                    "stop bit periods between frames", g, exp_stop[k]);
            else
                chk(g >= exp_stop[k], "R4", "trailing stop periods", g, exp_stop[k]);
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog: actual=timeout expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = 8'h00;
        stop_sel = 2'd0;
        repeat (5) @(negedge clk);
        chk(tx_line == 1'b1, "R1", "line during reset", tx_line, 1);
        chk(in_ready == 1'b1, "R1", "ready during reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line == 1'b1, "R1", "line after reset", tx_line, 1);
        chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

        // Table walk: back-to-back stream with mixed stop settings
        repeat (2 * P) @(negedge clk);
        log_n = 0;
        repeat (2 * P) @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            exp_data[v] = VEC[v][7:0];
            exp_stop[v] = int'(VEC[v][9:8]) + 1;
            send(VEC[v][7:0], VEC[v][9:8]);
        end
        repeat (16 * P) @(negedge clk);
        check_frames(NV);

        // Directed: ready closed mid-frame, stop setting changed mid-frame
        log_n = 0;
        repeat (2 * P) @(negedge clk);
        exp_data[0] = 8'hC5; exp_stop[0] = 1;
        exp_data[1] = 8'h6E; exp_stop[1] = 4;
        exp_data[2] = 8'h01; exp_stop[2] = 1;
        send(8'hC5, 2'd0);
        repeat (3 * P) @(negedge clk);
        chk(in_ready == 1'b0, "R6", "ready during data bits", in_ready, 0);
        stop_sel = 2'd3; // R7: must not stretch the running frame
        repeat (P) @(negedge clk);
        chk(in_ready == 1'b0, "R6", "ready later in data bits", in_ready, 0);
        send(8'h6E, 2'd3);
        send(8'h01, 2'd0);
        repeat (16 * P) @(negedge clk);
        check_frames(3);
        chk(in_ready == 1'b1 && tx_line == 1'b1, "R2", "idle after stream",
            {in_ready, tx_line}, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule